// File: doc/BRIEF.md
# Cascaded Audio Clock Generator

This block derives the three clocks that an audio converter needs from a single reference clock. The master clock is the reference divided by a programmable even divisor. The bit clock is the master clock divided by a fixed ratio. The frame clock, which selects the left or right channel, is the bit clock divided by a second fixed ratio. The bit-clock divider advances only on master-clock falling edges, and the frame-clock divider advances only on bit-clock falling edges, so the three clocks stay in step.

Software chooses the master divisor by dividing the reference frequency by the product of the sample rate and both ratios. The block clamps the requested divisor to a configured window, so an extreme sample-rate request still yields a usable rate. A stop pulse parks all three dividers at once. A start pulse launches them together in one cycle. On start, the first frame half-period is stretched by a fixed number of bit periods. This places the frame clock at a known phase against the bit clock. An active-low driver enable follows the running state one cycle later. A status flag marks the end of the first complete frame.

Top module: `audio_clk_cascade`

## Requirements
- R1: After reset, mclk, bclk, lrclk and aligned are low and drv_en_n is high.
- R2: While running with effective divisor D, mclk has a period of D reference cycles. It is high for the first D/2 cycles of each period, and its first rising edge comes D/2 cycles after the cycle in which start is sampled.
- R3: The divisor taken from div_req is clamped to the range DIV_MIN to DIV_MAX (defaults 4 and 32).
- R4: Bit 0 of div_req is ignored, so an odd request is rounded down to the next even divisor.
- R5: bclk has a period of D*M2B reference cycles and changes only when mclk falls. Its first rising edge comes D*M2B/2 cycles after start.
- R6: lrclk changes only when bclk falls. It is low (left channel) from start until its first rising edge.
- R7: lrclk first rises after FH+ALIGN bit periods, where FH = B2F/2. Every later half-period lasts FH bit periods, so the steady frame period is D*M2B*B2F reference cycles.
- R8: aligned rises on the same cycle in which lrclk ends its first high phase. It stays high until a stop.
- R9: drv_en_n goes low one cycle after start is accepted and goes high one cycle after stop.
- R10: A sampled stop sets mclk, bclk, lrclk and aligned low on the next edge. Stop takes priority over a simultaneous start.
- R11: While running, a start pulse and any change on div_req have no effect on the clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_req | input | DIV_W | Requested master divisor, captured when start is accepted |
| start | input | 1 | Launch all dividers (ignored while running) |
| stop | input | 1 | Park all dividers (wins over start) |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock, low for left |
| drv_en_n | output | 1 | Active-low enable for the clock drivers |
| aligned | output | 1 | First full frame after start has completed |

## Verification
All results are measured from the edge that samples start. With D=8 and the default ratios, the first mclk rise is due 4 cycles after that edge. The first bclk rise is due 16 cycles after it, the first lrclk rise 224 cycles after it, and the aligned rise together with the first lrclk fall 352 cycles after it. drv_en_n follows start or stop one cycle later, and a stop clears the clocks on the very next edge. A free-running cycle counter timestamps each observation at the falling clock edge. The bench compares elapsed counts against these values, and compares periods rise-to-rise, so every check lands on the exact cycle the requirement names.

// File: rtl/audio_clk_cascade.sv
module audio_clk_cascade #(
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 4,
  parameter int DIV_MAX = 32,
  parameter int M2B     = 4,
  parameter int B2F     = 8,
  parameter int ALIGN   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_req,
  input  logic             start,
  input  logic             stop,
  output logic             mclk,
  output logic             bclk,
  output logic             lrclk,
  output logic             drv_en_n,
  output logic             aligned
);
  localparam int HW = DIV_W - 1;
  localparam int BH = M2B / 2;
  localparam int BW = (BH > 1) ? $clog2(BH) : 1;
  localparam int FH = B2F / 2;
  localparam int LIM_FIRST = FH + ALIGN;
  localparam int LW = $clog2(LIM_FIRST + 1);
  localparam logic [BW-1:0] B_LAST  = BW'(BH - 1);
  localparam logic [LW-1:0] L_FIRST = LW'(LIM_FIRST - 1);
  localparam logic [LW-1:0] L_NORM  = LW'(FH - 1);

  logic [DIV_W-1:0] div_clamp;
  logic [HW-1:0]    half_q, mcnt;
  logic [BW-1:0]    bcnt;
  logic [LW-1:0]    lcnt;
  logic             run_q, first_q;
  logic             mtog, mfall, btog, bfall, ltog;

  assign div_clamp = (div_req < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) :
                     (div_req > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : div_req;

  assign mtog  = run_q && (mcnt == half_q - 1'b1);
  assign mfall = mtog && mclk;
  assign btog  = mfall && (bcnt == B_LAST);
  assign bfall = btog && bclk;
  assign ltog  = bfall && (lcnt == (first_q ? L_FIRST : L_NORM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; first_q <= 1'b0; half_q <= '0;
      mcnt <= '0; bcnt <= '0; lcnt <= '0;
      mclk <= 1'b0; bclk <= 1'b0; lrclk <= 1'b0; aligned <= 1'b0;
    end else if (stop) begin
      run_q <= 1'b0; first_q <= 1'b0;
      mcnt <= '0; bcnt <= '0; lcnt <= '0;
      mclk <= 1'b0; bclk <= 1'b0; lrclk <= 1'b0; aligned <= 1'b0;
    end else if (!run_q) begin
      if (start) begin
        run_q   <= 1'b1;
        first_q <= 1'b1;
        half_q  <= div_clamp[DIV_W-1:1];
      end
    end else begin
      mcnt <= mtog ? '0 : mcnt + 1'b1;
      if (mtog) mclk <= ~mclk;
      if (mfall) bcnt <= (bcnt == B_LAST) ? '0 : bcnt + 1'b1;
      if (btog) bclk <= ~bclk;
      if (bfall) lcnt <= ltog ? '0 : lcnt + 1'b1;
      if (ltog) begin
        lrclk   <= ~lrclk;
        first_q <= 1'b0;
        if (lrclk) aligned <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_en_n <= 1'b1;
    else        drv_en_n <= ~run_q;
  end
endmodule

// File: rtl/audio_clk_cascade_chk.sv
module audio_clk_cascade_chk (
  input logic clk,
  input logic rst_n,
  input logic stop,
  input logic mclk,
  input logic bclk,
  input logic lrclk,
  input logic drv_en_n,
  input logic aligned
);
  assert_bclk_on_mfall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bclk) && !$past(stop)) |-> $fell(mclk));

  assert_lrclk_on_bfall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lrclk) && !$past(stop)) |-> $fell(bclk));

  assert_aligned_at_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $fell(lrclk));

  assert_aligned_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aligned) |-> $past(stop));

  assert_quiet_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_n |-> (!mclk && !bclk && !lrclk && !aligned));

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!mclk && !bclk && !lrclk && !aligned));
endmodule

bind audio_clk_cascade audio_clk_cascade_chk u_chk (.*);

// File: tb/sim_audio_clk_cascade.sv
`timescale 1ns/1ps
module sim_audio_clk_cascade;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic [7:0] div_req = 8'd8;
  logic mclk, bclk, lrclk, drv_en_n, aligned;
  int errors = 0, checks = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_clk_cascade u0 (.clk(clk), .rst_n(rst_n), .div_req(div_req), .start(start),
    .stop(stop), .mclk(mclk), .bclk(bclk), .lrclk(lrclk), .drv_en_n(drv_en_n),
    .aligned(aligned));

  function automatic logic sig(int w);
    case (w)
      0: return mclk;
      1: return bclk;
      2: return lrclk;
      default: return aligned;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(int w);
    while (sig(w) !== 1'b0) @(negedge clk);
    while (sig(w) !== 1'b1) @(negedge clk);
  endtask

  task automatic gap(int w, output int p);
    int t0;
    wait_rise(w); t0 = cyc;
    wait_rise(w); p = cyc - t0;
  endtask

  task automatic do_start(logic [7:0] d);
    @(negedge clk); div_req = d; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_reset();
    check(!mclk && !bclk && !lrclk && !aligned, "R1 clocks low", {mclk,bclk,lrclk,aligned}, 0);
    check(drv_en_n === 1'b1, "R1 drv_en_n high", drv_en_n, 1);
  endtask

  task automatic t_launch();
    int n = 1, t_d = -1, t_m = -1, t_b = -1, t_lr = -1, t_lf = -1, t_al = -1;
    bit lr_low_early = 1;
    do_start(8'd8);
    while (n <= 400) begin
      if (t_d < 0 && !drv_en_n) t_d = n;
      if (t_m < 0 && mclk) t_m = n;
      if (t_b < 0 && bclk) t_b = n;
      if (t_lr < 0 && lrclk) t_lr = n;
      if (t_lr >= 0 && t_lf < 0 && !lrclk) t_lf = n;
      if (t_al < 0 && aligned) t_al = n;
      if (n < 225 && lrclk) lr_low_early = 0;
      @(negedge clk); n++;
    end
    check(t_d == 2, "R9 drv_en_n low after start", t_d, 2);
    check(t_m == 5, "R2 first mclk rise", t_m, 5);
    check(t_b == 17, "R5 first bclk rise", t_b, 17);
    check(lr_low_early, "R6 lrclk low before first rise", lr_low_early, 1);
    check(t_lr == 225, "R7 first lrclk rise", t_lr, 225);
    check(t_lf == 353, "R7 first lrclk fall", t_lf, 353);
    check(t_al == 353, "R8 aligned rise", t_al, 353);
  endtask

  task automatic t_periods();
    int p;
    gap(0, p); check(p == 8, "R2 mclk period", p, 8);
    gap(1, p); check(p == 32, "R5 bclk period", p, 32);
    gap(2, p); check(p == 256, "R7 frame period", p, 256);
    check(aligned === 1'b1, "R8 aligned held", aligned, 1);
  endtask

  task automatic t_ignore();
    int p, t0;
    @(negedge clk); div_req = 8'd16;
    gap(0, p); check(p == 8, "R11 div_req change ignored", p, 8);
    wait_rise(2); t0 = cyc;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_rise(2); p = cyc - t0;
    check(p == 256, "R11 start while running ignored", p, 256);
    check(aligned === 1'b1, "R11 aligned kept", aligned, 1);
  endtask

  task automatic t_stop();
    do_stop();
    check(!mclk && !bclk && !lrclk && !aligned, "R10 stop clears", {mclk,bclk,lrclk,aligned}, 0);
    check(drv_en_n === 1'b0, "R9 drv_en_n still low at stop edge", drv_en_n, 0);
    @(negedge clk);
    check(drv_en_n === 1'b1, "R9 drv_en_n high after stop", drv_en_n, 1);
  endtask

  task automatic t_div(logic [7:0] d, int exp, string req);
    int p;
    do_start(d);
    gap(0, p); check(p == exp, req, p, exp);
    do_stop();
  endtask

  task automatic t_priority();
    bit seen = 0;
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    repeat (30) begin
      if (mclk || !drv_en_n) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R10 stop wins over start", seen, 0);
  endtask

  initial begin
    #(5ns * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_launch();
    t_periods();
    t_ignore();
    t_stop();
    t_div(8'd2, 4, "R3 clamp low");
    t_div(8'd200, 32, "R3 clamp high");
    t_div(8'd9, 8, "R4 odd rounded down");
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule